// File: doc/BRIEF.md
# Memory Type Range Resolver

This block maps a physical address to the cache memory type that governs it. Software loads a small set of configuration registers through a single write port: a control word, a fixed-range table for the first megabyte, a bank of variable base/mask pairs, and an upper boundary for a writeback window above 4 GiB. Each cycle with `lk_valid` high, the block resolves `lk_addr` against that configuration and returns an 8-bit type code one cycle later, with a valid strobe.

Resolution follows a fixed order. A cleared global enable forces uncacheable. Next, an address below 1 MiB reads the fixed table when the fixed ranges are enabled. Next, an address inside the upper writeback window resolves to writeback. After that, the variable ranges are matched and merged by a precedence rule, and the default type is used when nothing matches. Mixes that the precedence rule does not define set a conflict flag and report uncacheable.

The resolver has no sequential control. The source of the result (`SRC_OFF`, `SRC_FIXED`, `SRC_HIGH`, `SRC_VAR`, `SRC_DEF`) is selected combinationally and decoded by one `unique case`. One output register stage follows it.

Top module: `mtr_resolver`

## Requirements
- R1: While control bit 11 (global enable) is 0, every lookup returns type 0 (uncacheable) with conflict 0.
- R2: With the global enable set and control bit 10 set, an address below 0x100000 takes its type from the fixed table. Fixed register 0 holds eight 64 KiB blocks from 0. Registers 1–2 hold 16 KiB blocks from 0x80000. Registers 3–10 hold 4 KiB blocks from 0xC0000. Block k inside a register uses byte lane k (bits 8k+7:8k). Address 0x100000 and above never uses the table.
- R3: With control bit 10 cleared, addresses below 0x100000 resolve through the variable ranges and the default, as other addresses do.
- R4: A variable pair matches when (addr & −size) equals the base with bits 11:0 cleared. Here size = (all-ones PA_W mask XOR mask-with-bits-11:0-cleared) + 1. The pair's type is base bits 7:0. A pair whose mask bit 11 is 0 never matches.
- R5: With the global enable set and no other source applying, the result is control bits 7:0.
- R6: Among matching variable pairs, identical types yield that type, and any uncacheable (0) match yields 0.
- R7: A match set made of only write-through (4) and writeback (6) yields 4.
- R8: Any other mix of matching types sets conflict to 1 and reports type 0.
- R9: With the global enable set, an address ≥ 0x1_0000_0000 and below the boundary register resolves to writeback (6), ahead of the variable ranges. A boundary of 0 disables the window.
- R10: `res_valid` is high exactly in the cycle after a cycle with `lk_valid` high, and carries that lookup's result.
- R11: After reset all registers are 0 and `res_valid` is 0, so lookups resolve to type 0.
- R12: Writes take effect only while `wr_en` is 1. Selector 0 is control, 1 is the boundary, 2+k is fixed register k (k = 0..10), 32+2i is variable base i and 33+2i is variable mask i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 6 | Register selector |
| wr_data | input | 64 | Write data |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | PA_W | Physical address to resolve |
| res_valid | output | 1 | Result valid, one cycle after request |
| res_type | output | 8 | Resolved memory type code |
| res_conflict | output | 1 | Undefined overlap of variable ranges |

## Verification
The assertions assume a configuration in which `PA_W` exceeds 32, so that the 4 GiB window test is meaningful. They also assume that a register write in the same cycle as a lookup is seen only by later lookups. The bench writes registers in cycles of their own and starts each lookup on a later falling edge. It writes every variable mask with its low twelve bits clear except the valid bit, so each programmed range is a clean power-of-two block that the expected values can be derived from by hand.

// File: rtl/mtr_pkg.sv
package mtr_pkg;

    typedef logic [7:0] mtype_t;

    localparam mtype_t MT_UC = 8'd0;
    localparam mtype_t MT_WC = 8'd1;
    localparam mtype_t MT_WT = 8'd4;
    localparam mtype_t MT_WP = 8'd5;
    localparam mtype_t MT_WB = 8'd6;

    localparam int SEL_W      = 6;
    localparam int SEL_CTRL   = 0;
    localparam int SEL_BOUND  = 1;
    localparam int SEL_FIX0   = 2;
    localparam int SEL_VAR0   = 32;

    localparam int NUM_FIX    = 11;
    localparam int CTL_FIX_BIT = 10;
    localparam int CTL_EN_BIT  = 11;
    localparam int VAR_VALID_BIT = 11;

    typedef enum logic [2:0] {
        SRC_OFF   = 3'd0,
        SRC_FIXED = 3'd1,
        SRC_HIGH  = 3'd2,
        SRC_VAR   = 3'd3,
        SRC_DEF   = 3'd4
    } src_e;

endpackage

// File: rtl/mtr_regfile.sv
module mtr_regfile
    import mtr_pkg::*;
#(
    parameter int PA_W    = 36,
    parameter int NUM_VAR = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [SEL_W-1:0]              wr_sel,
    input  logic [63:0]                   wr_data,
    output mtype_t                        def_type_q,
    output logic                          fix_en_q,
    output logic                          glob_en_q,
    output logic [PA_W-1:0]               bound_q,
    output logic [NUM_FIX-1:0][63:0]      fix_q,
    output logic [NUM_VAR-1:0][PA_W-1:0]  var_base_q,
    output logic [NUM_VAR-1:0][PA_W-1:0]  var_mask_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            def_type_q <= MT_UC;
            fix_en_q   <= 1'b0;
            glob_en_q  <= 1'b0;
        end else if (wr_en && wr_sel == SEL_W'(SEL_CTRL)) begin
            def_type_q <= wr_data[7:0];
            fix_en_q   <= wr_data[CTL_FIX_BIT];
            glob_en_q  <= wr_data[CTL_EN_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bound_q <= '0;
        end else if (wr_en && wr_sel == SEL_W'(SEL_BOUND)) begin
            bound_q <= wr_data[PA_W-1:0];
        end
    end

    for (genvar k = 0; k < NUM_FIX; k++) begin : g_fix
        localparam int SEL_K = SEL_FIX0 + k;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                fix_q[k] <= '0;
            end else if (wr_en && wr_sel == SEL_W'(SEL_K)) begin
                fix_q[k] <= wr_data;
            end
        end
    end

    for (genvar i = 0; i < NUM_VAR; i++) begin : g_var
        localparam int SEL_B = SEL_VAR0 + 2 * i;
        localparam int SEL_M = SEL_VAR0 + 2 * i + 1;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                var_base_q[i] <= '0;
                var_mask_q[i] <= '0;
            end else if (wr_en) begin
                if (wr_sel == SEL_W'(SEL_B)) var_base_q[i] <= wr_data[PA_W-1:0];
                if (wr_sel == SEL_W'(SEL_M)) var_mask_q[i] <= wr_data[PA_W-1:0];
            end
        end
    end

endmodule

// File: rtl/mtr_fixed_lookup.sv
module mtr_fixed_lookup
    import mtr_pkg::*;
(
    input  logic [19:12]             page,
    input  logic [NUM_FIX-1:0][63:0] fix_q,
    output mtype_t                   fix_type
);

    logic [3:0] reg_idx;
    logic [2:0] lane;

    always_comb begin
        if (!page[19]) begin
            reg_idx = 4'd0;
            lane    = page[18:16];
        end else if (!page[18]) begin
            reg_idx = 4'd1 + {3'd0, page[17]};
            lane    = page[16:14];
        end else begin
            reg_idx = 4'd3 + {1'b0, page[17:15]};
            lane    = page[14:12];
        end
    end

    always_comb begin
        fix_type = MT_UC;
        for (int k = 0; k < NUM_FIX; k++) begin
            if (reg_idx == 4'(k)) fix_type = fix_q[k][{lane, 3'b000} +: 8];
        end
    end

endmodule

// File: rtl/mtr_var_resolve.sv
module mtr_var_resolve
    import mtr_pkg::*;
#(
    parameter int PA_W    = 36,
    parameter int NUM_VAR = 8
) (
    input  logic [PA_W-1:0]               addr,
    input  logic [NUM_VAR-1:0][PA_W-1:0]  var_base_q,
    input  logic [NUM_VAR-1:0][PA_W-1:0]  var_mask_q,
    output logic                          any_hit,
    output mtype_t                        var_type,
    output logic                          var_conflict
);

    localparam logic [PA_W-1:0] PA_MASK  = '1;
    localparam logic [PA_W-1:0] LOW_MASK = PA_W'(4095);

    logic   [NUM_VAR-1:0] hit;
    mtype_t [NUM_VAR-1:0] hit_type;

    for (genvar i = 0; i < NUM_VAR; i++) begin : g_pair
        logic [PA_W-1:0] mask_hi;
        logic [PA_W-1:0] span;
        logic [PA_W-1:0] span_neg;
        assign mask_hi     = var_mask_q[i] & ~LOW_MASK;
        assign span        = (PA_MASK ^ mask_hi) + PA_W'(1);
        assign span_neg    = -span;
        assign hit[i]      = var_mask_q[i][VAR_VALID_BIT] &&
                             ((addr & span_neg) == (var_base_q[i] & ~LOW_MASK));
        assign hit_type[i] = var_base_q[i][7:0];
    end

    logic   seen;
    logic   seen_uc;
    logic   all_same;
    logic   only_wtwb;
    mtype_t first_type;

    always_comb begin
        seen       = 1'b0;
        seen_uc    = 1'b0;
        all_same   = 1'b1;
        only_wtwb  = 1'b1;
        first_type = MT_UC;
        for (int i = 0; i < NUM_VAR; i++) begin
            if (hit[i]) begin
                if (!seen) first_type = hit_type[i];
                else if (hit_type[i] != first_type) all_same = 1'b0;
                seen = 1'b1;
                if (hit_type[i] == MT_UC) seen_uc = 1'b1;
                if (hit_type[i] != MT_WT && hit_type[i] != MT_WB) only_wtwb = 1'b0;
            end
        end
    end

    always_comb begin
        any_hit      = seen;
        var_conflict = 1'b0;
        if (seen_uc) begin
            var_type = MT_UC;
        end else if (all_same) begin
            var_type = first_type;
        end else if (only_wtwb) begin
            var_type = MT_WT;
        end else begin
            var_type     = MT_UC;
            var_conflict = 1'b1;
        end
    end

endmodule

// File: rtl/mtr_resolver.sv
module mtr_resolver
    import mtr_pkg::*;
#(
    parameter int PA_W    = 36,
    parameter int NUM_VAR = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [5:0]       wr_sel,
    input  logic [63:0]      wr_data,
    input  logic             lk_valid,
    input  logic [PA_W-1:0]  lk_addr,
    output logic             res_valid,
    output logic [7:0]       res_type,
    output logic             res_conflict
);

    mtype_t                        def_type_q;
    logic                          fix_en_q;
    logic                          glob_en;
    logic [PA_W-1:0]               bound_q;
    logic [NUM_FIX-1:0][63:0]      fix_q;
    logic [NUM_VAR-1:0][PA_W-1:0]  var_base_q;
    logic [NUM_VAR-1:0][PA_W-1:0]  var_mask_q;

    mtr_regfile #(.PA_W(PA_W), .NUM_VAR(NUM_VAR)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .def_type_q (def_type_q),
        .fix_en_q   (fix_en_q),
        .glob_en_q  (glob_en),
        .bound_q    (bound_q),
        .fix_q      (fix_q),
        .var_base_q (var_base_q),
        .var_mask_q (var_mask_q)
    );

    mtype_t fix_type;

    mtr_fixed_lookup fixed_i (
        .page     (lk_addr[19:12]),
        .fix_q    (fix_q),
        .fix_type (fix_type)
    );

    logic   any_hit;
    mtype_t var_type;
    logic   var_conflict;

    mtr_var_resolve #(.PA_W(PA_W), .NUM_VAR(NUM_VAR)) var_i (
        .addr         (lk_addr),
        .var_base_q   (var_base_q),
        .var_mask_q   (var_mask_q),
        .any_hit      (any_hit),
        .var_type     (var_type),
        .var_conflict (var_conflict)
    );

    logic in_low_meg;
    logic in_high_win;
    src_e src;

    assign in_low_meg  = (lk_addr[PA_W-1:20] == '0);
    assign in_high_win = (lk_addr[PA_W-1:32] != '0) && (lk_addr < bound_q);

    // Source selection, in fixed precedence order.
    always_comb begin
        if (!glob_en)                     src = SRC_OFF;
        else if (in_low_meg && fix_en_q)  src = SRC_FIXED;
        else if (in_high_win)             src = SRC_HIGH;
        else if (any_hit)                 src = SRC_VAR;
        else                              src = SRC_DEF;
    end

    mtype_t type_d;
    logic   conflict_d;

    always_comb begin
        type_d     = MT_UC;
        conflict_d = 1'b0;
        unique case (src)
            SRC_OFF:   type_d = MT_UC;
            SRC_FIXED: type_d = fix_type;
            SRC_HIGH:  type_d = MT_WB;
            SRC_VAR: begin
                type_d     = var_type;
                conflict_d = var_conflict;
            end
            SRC_DEF:   type_d = def_type_q;
            default:   type_d = MT_UC;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid    <= 1'b0;
            res_type     <= MT_UC;
            res_conflict <= 1'b0;
        end else begin
            res_valid <= lk_valid;
            if (lk_valid) begin
                res_type     <= type_d;
                res_conflict <= conflict_d;
            end
        end
    end

endmodule

// File: rtl/mtr_resolver_chk.sv
module mtr_resolver_chk #(
    parameter int PA_W = 36
) (
    input logic            clk,
    input logic            rst_n,
    input logic            lk_valid,
    input logic [PA_W-1:0] lk_addr,
    input logic            glob_en,
    input logic [PA_W-1:0] bound_q,
    input logic            res_valid,
    input logic [7:0]      res_type,
    input logic            res_conflict
);

    logic high_req;
    assign high_req = lk_valid && glob_en && ((lk_addr >> 32) != '0) && (lk_addr < bound_q);

    assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid);

    assert_no_spurious_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !res_valid);

    assert_disabled_uc_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !glob_en) |=> (res_type == 8'd0 && !res_conflict));

    assert_conflict_reports_uc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        res_conflict |-> (res_type == 8'd0));

    assert_high_window_wb_R9: assert property (@(posedge clk) disable iff (!rst_n)
        high_req |=> (res_type == 8'd6 && !res_conflict));

endmodule

bind mtr_resolver mtr_resolver_chk #(.PA_W(PA_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .lk_valid     (lk_valid),
    .lk_addr      (lk_addr),
    .glob_en      (glob_en),
    .bound_q      (bound_q),
    .res_valid    (res_valid),
    .res_type     (res_type),
    .res_conflict (res_conflict)
);

// File: tb/mtr_resolver_tb_top.sv
`timescale 1ns/1ps
module mtr_resolver_tb_top;

    localparam int PA_W = 36;
    localparam logic [63:0] PAM = (64'd1 << PA_W) - 64'd1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic [5:0]      wr_sel = '0;
    logic [63:0]     wr_data = '0;
    logic            lk_valid = 1'b0;
    logic [PA_W-1:0] lk_addr = '0;
    logic            res_valid;
    logic [7:0]      res_type;
    logic            res_conflict;

    always #2.5 clk = ~clk;

    mtr_resolver #(.PA_W(PA_W), .NUM_VAR(8)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_sel       (wr_sel),
        .wr_data      (wr_data),
        .lk_valid     (lk_valid),
        .lk_addr      (lk_addr),
        .res_valid    (res_valid),
        .res_type     (res_type),
        .res_conflict (res_conflict)
    );

    typedef struct {
        logic [7:0] t;
        logic       c;
        string      tag;
    } exp_t;

    exp_t sb_q[$];
    int   n_vec  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;

    function automatic logic [63:0] mk_mask(input logic [63:0] size);
        return (PAM & ~(size - 64'd1)) | 64'h800;
    endfunction

    task automatic wr(input int sel, input logic [63:0] d);
        wr_en = 1'b1; wr_sel = 6'(sel); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic look(input logic [63:0] a, input logic [7:0] t, input logic c, input string tag);
        exp_t e;
        e.t = t; e.c = c; e.tag = tag;
        lk_valid = 1'b1; lk_addr = a[PA_W-1:0];
        sb_q.push_back(e);
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    // Monitor: pops one expected item per valid result.
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            if (sb_q.size() == 0) begin
                n_vec++; n_fail++;
                $display("FAIL R10: res_valid=1 with no pending lookup (expected 0)");
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                n_vec++;
                if (res_type !== e.t || res_conflict !== e.c) begin
                    n_fail++;
                    $display("FAIL %s: type=%0d conflict=%0b, expected type=%0d conflict=%0b",
                             e.tag, res_type, res_conflict, e.t, e.c);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_vec++; n_fail++;
            $display("FAIL watchdog: run did not complete (expected completion)");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        n_vec++;
        if (res_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R11: res_valid=%0b after reset, expected 0", res_valid);
        end
        look(64'h1000, 8'd0, 1'b0, "R11");

        wr(0, 64'h806);
        look(64'h2000_0000, 8'd6, 1'b0, "R5");

        wr(32, 64'h1000_0001); wr(33, mk_mask(64'h1000_0000));
        look(64'h1234_5678, 8'd1, 1'b0, "R4");
        look(64'h0FFF_FFFF, 8'd6, 1'b0, "R5");

        wr(34, 64'h1000_0001); wr(35, mk_mask(64'h1000));
        look(64'h1000_0000, 8'd1, 1'b0, "R6");
        wr(34, 64'h1000_0000);
        look(64'h1000_0000, 8'd0, 1'b0, "R6");
        look(64'h1000_1000, 8'd1, 1'b0, "R6");

        wr(36, 64'h3000_0004); wr(37, 64'hF_F000_0000);
        look(64'h3000_0000, 8'd6, 1'b0, "R4");

        wr(38, 64'h4000_0006); wr(39, mk_mask(64'h1000_0000));
        wr(40, 64'h4000_0004); wr(41, mk_mask(64'h100_0000));
        look(64'h4080_0000, 8'd4, 1'b0, "R7");
        look(64'h4100_0000, 8'd6, 1'b0, "R7");

        wr(42, 64'h5000_0005); wr(43, mk_mask(64'h1000_0000));
        wr(44, 64'h5000_0001); wr(45, mk_mask(64'h1000));
        look(64'h5000_0000, 8'd0, 1'b1, "R8");
        look(64'h5000_1000, 8'd5, 1'b0, "R8");

        wr(1, 64'h1_8000_0000);
        wr(46, 64'h1_0000_0000); wr(47, mk_mask(64'h1_0000_0000));
        look(64'h1_4000_0000, 8'd6, 1'b0, "R9");
        look(64'h1_8000_0000, 8'd0, 1'b0, "R9");

        wr(0, 64'h805);
        look(64'h2000_0000, 8'd5, 1'b0, "R5");
        look(64'h2_0000_0000, 8'd5, 1'b0, "R5");

        wr(36, 64'h0000_0001); wr(37, mk_mask(64'h20_0000));
        wr(0, 64'hC05);
        wr(2,  64'h0605_0401_0006_0504);
        wr(3,  64'h0000_0000_0000_0100);
        wr(4,  64'h0400_0000_0000_0000);
        wr(5,  64'h0000_0000_0000_0600);
        wr(12, 64'h0500_0000_0000_0000);
        look(64'h3_0000, 8'd0, 1'b0, "R2");
        look(64'h7_FFFF, 8'd6, 1'b0, "R2");
        look(64'h1_0000, 8'd5, 1'b0, "R2");
        look(64'h8_4000, 8'd1, 1'b0, "R2");
        look(64'h8_0000, 8'd0, 1'b0, "R2");
        look(64'hB_C000, 8'd4, 1'b0, "R2");
        look(64'hC_1000, 8'd6, 1'b0, "R2");
        look(64'hF_F000, 8'd5, 1'b0, "R2");
        look(64'hF_E000, 8'd0, 1'b0, "R2");
        look(64'h10_0000, 8'd1, 1'b0, "R2");

        wr(0, 64'h805);
        look(64'h3_0000, 8'd1, 1'b0, "R3");

        wr_en = 1'b0; wr_sel = 6'd0; wr_data = 64'h0;
        @(negedge clk);
        look(64'h3_0000, 8'd1, 1'b0, "R12");

        wr(0, 64'h005);
        look(64'h1_4000_0000, 8'd0, 1'b0, "R1");
        look(64'h5000_0000, 8'd0, 1'b0, "R1");

        repeat (3) @(negedge clk);
        n_vec++;
        if (sb_q.size() != 0) begin
            n_fail++;
            $display("FAIL R10: %0d results missing, expected 0", sb_q.size());
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule